// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is a bus target for a two-wire serial control bus that keeps a small bank of configuration registers for an analog front end. A host selects it with a 7-bit address made of a fixed five-bit prefix and two strap pins, so four instances can sit on the same pair of wires. The first data byte of a write sets an internal register pointer, and every further byte is stored at the pointer, which then steps by one. Reads return the pointed register and also step the pointer, so one pointer set followed by a repeated START and a read gives a run of consecutive registers.

The bank has a read-only identity byte at index 0, twelve writable bytes at indices 1 to 12 with their own reset values, and a calibration command bit (bit 0 of index 12) that software sets and a hardware done pulse clears. Indices 13 and up hold nothing. Both bus lines pass through a synchronizer and a majority-free agreement filter before any edge is recognised, and the data line is only ever pulled low or released.

Top module: `i2c_cfg_target`

## Requirements
- R1: The target answers (pulls the data line low in the acknowledge slot) to the address byte whose upper seven bits equal 1,0,0,0,1 then strap[1] then strap[0], for each of the four strap values.
- R2: Any other address is not acknowledged, and bytes clocked after it are ignored until the next START.
- R3: After a matching address with the read/write bit 0, the first byte loads the pointer; each later byte is written to the pointed index and the pointer then steps by one, modulo 256.
- R4: A read returns the byte at the pointer and steps the pointer once per byte; a repeated START after a pointer-setting write turns the transfer into a read from that pointer, and a fresh read with no pointer byte continues where the last one stopped.
- R5: Index 0 reads as {DEV_ID, DEV_REV} (0x10 with default parameters); writes to it are acknowledged and change nothing.
- R6: After reset index 1 holds 0x02, indices 6, 7 and 8 hold 0x40, and every other writable index holds 0x00.
- R7: Writes to indices 13 and above are acknowledged and change nothing; reads of those indices return 0x00.
- R8: Bit 0 of index 12 appears on cal_busy; it is set by a bus write and cleared by a one-cycle cal_done pulse, with the other bits of index 12 kept.
- R9: A pulse on either bus line that lasts fewer than three system-clock samples after synchronisation is ignored.
- R10: The target drives the data line only low, changes it only after a falling clock edge, and releases it after the host answers a read byte with NACK.
- R11: cfg_bank carries writable index k in bits [8k-1:8k-8].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap | input | 2 | Low two address bits from board straps |
| cal_done | input | 1 | One-cycle pulse that clears the calibration command bit |
| sda_pull | output | 1 | High to pull the data line low (open-drain enable) |
| cfg_bank | output | 96 | Writable indices 1 to 12, eight bits each |
| cal_busy | output | 1 | Calibration command bit |

## Verification
Directed transfers cover the identity read, writes aimed at the read-only and empty indices, a wrong prefix, a wrong strap and each strap value, which separates address matching from register decoding. Random transfers with random start index and length, crossing the boundary into the empty range, tell apart pointer stepping on writes, on reads and across a repeated START. Two-cycle pulses on the clock line while it is low and on the data line while the clock is high show whether the filter rejects them, since an accepted pulse would shift in an extra bit or fake a START or STOP. The calibration bit is set over the bus and cleared by the done pulse to separate the two writers of that bit.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WR,
      ST_WACK,
      ST_RD,
      ST_RACK
   } bus_st_t;

   // Power-up value of each writable register index.
   function automatic logic [7:0] reg_default(input int idx);
      case (idx)
         1:       return 8'h02;
         6, 7, 8: return 8'h40;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [FILT_LEN-1:0]    win_q;
   logic                   sync_o;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 3) begin : g_bad_filt
         $error("FILT_LEN must be at least 3");
      end
   endgenerate

   assign sync_o = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         win_q  <= '1;
         clean  <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
         win_q  <= {win_q[FILT_LEN-2:0], sync_o};
         if (&win_q)
            clean <= 1'b1;
         else if (~|win_q)
            clean <= 1'b0;
      end
   end

   // R9: a new level is accepted only once the synchronized line carried it
   assert_glitch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clean) |-> ($past(sync_o, 2) == clean));

endmodule

// File: rtl/i2c_bus_engine.sv
module i2c_bus_engine
   import i2c_cfg_pkg::*;
#(
   parameter logic [4:0] ADDR_PREFIX = 5'b10001
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl,
   input  logic       sda,
   input  logic [1:0] strap,
   input  logic [7:0] rd_data,
   output logic       sda_oe,
   output logic       wr_stb,
   output logic [7:0] wr_addr,
   output logic [7:0] wr_data,
   output logic [7:0] ptr
);

   localparam int BITS = 8;

   bus_st_t    state;
   logic       s_q, d_q;
   logic [3:0] cnt;
   logic [7:0] rx, tx;
   logic       rw, ptr_phase, nack;
   logic       s_rise, s_fall, start_c, stop_c;

   assign s_rise  = scl & ~s_q;
   assign s_fall  = ~scl & s_q;
   assign start_c = scl & s_q & d_q & ~sda;
   assign stop_c  = scl & s_q & ~d_q & sda;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         s_q       <= 1'b1;
         d_q       <= 1'b1;
         cnt       <= '0;
         rx        <= '0;
         tx        <= '0;
         rw        <= 1'b0;
         ptr_phase <= 1'b0;
         nack      <= 1'b0;
         sda_oe    <= 1'b0;
         wr_stb    <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         ptr       <= '0;
      end else begin
         s_q    <= scl;
         d_q    <= sda;
         wr_stb <= 1'b0;
         if (start_c) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_c) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_WR: begin
                  if (s_rise && cnt < 4'(BITS)) begin
                     rx  <= {rx[6:0], sda};
                     cnt <= cnt + 4'd1;
                  end else if (s_fall && cnt == 4'(BITS)) begin
                     if (state == ST_ADDR) begin
                        if (rx[7:1] == {ADDR_PREFIX, strap}) begin
                           sda_oe    <= 1'b1;
                           rw        <= rx[0];
                           ptr_phase <= ~rx[0];
                           state     <= ST_AACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else begin
                        sda_oe <= 1'b1;
                        state  <= ST_WACK;
                        if (ptr_phase) begin
                           ptr       <= rx;
                           ptr_phase <= 1'b0;
                        end else begin
                           wr_stb  <= 1'b1;
                           wr_addr <= ptr;
                           wr_data <= rx;
                           ptr     <= ptr + 8'd1;
                        end
                     end
                  end
               end
               ST_AACK: begin
                  if (s_fall) begin
                     cnt <= '0;
                     if (rw) begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        ptr    <= ptr + 8'd1;
                        state  <= ST_RD;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_WR;
                     end
                  end
               end
               ST_WACK: begin
                  if (s_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (s_rise) begin
                     cnt <= cnt + 4'd1;
                  end else if (s_fall) begin
                     if (cnt == 4'(BITS)) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RACK;
                     end else begin
                        tx     <= {tx[6:0], 1'b0};
                        sda_oe <= ~tx[6];
                     end
                  end
               end
               ST_RACK: begin
                  if (s_rise) begin
                     nack <= sda;
                  end else if (s_fall) begin
                     if (nack) begin
                        state <= ST_IDLE;
                     end else begin
                        cnt    <= '0;
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        ptr    <= ptr + 8'd1;
                        state  <= ST_RD;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R3: every stored byte leaves the pointer one past the index it went to
   assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (ptr == wr_addr + 8'd1));

   // R2: an idle target never holds the data line
   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   // R10: a STOP on the bus releases the data line
   assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_c |=> !sda_oe);

   // R10: the data line only moves while the clock is low
   assert_change_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl) || $past(start_c) || $past(stop_c));

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
   import i2c_cfg_pkg::*;
#(
   parameter int         NREG_RW = 12,
   parameter int         CAL_REG = 12,
   parameter logic [3:0] DEV_ID  = 4'h1,
   parameter logic [3:0] DEV_REV = 4'h0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_stb,
   input  logic [7:0]             wr_addr,
   input  logic [7:0]             wr_data,
   input  logic                   cal_done,
   input  logic [7:0]             rd_addr,
   output logic [7:0]             rd_data,
   output logic [NREG_RW*8-1:0]   bank,
   output logic                   cal_busy
);

   localparam int BANK_W = NREG_RW * 8;

   generate
      if (NREG_RW < 1 || NREG_RW > 255) begin : g_bad_n
         $error("NREG_RW out of range");
      end
      if (CAL_REG < 1 || CAL_REG > NREG_RW) begin : g_bad_cal
         $error("CAL_REG must be a writable index");
      end
      for (genvar k = 1; k <= NREG_RW; k++) begin : g_reg
         localparam logic [7:0] RST_V = reg_default(k);
         logic [7:0] q;
         if (k == CAL_REG) begin : g_cal
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= RST_V;
               else if (wr_stb && wr_addr == 8'(k))
                  q <= wr_data;
               else if (cal_done)
                  q[0] <= 1'b0;
            end
         end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= RST_V;
               else if (wr_stb && wr_addr == 8'(k))
                  q <= wr_data;
            end
         end
         assign bank[k*8-1 -: 8] = q;
      end
   endgenerate

   assign cal_busy = bank[CAL_REG*8-8];

   always_comb begin
      rd_data = 8'h00;
      if (rd_addr == 8'h00)
         rd_data = {DEV_ID, DEV_REV};
      for (int k = 1; k <= NREG_RW; k++)
         if (rd_addr == 8'(k))
            rd_data = bank[k*8-1 -: 8];
   end

   // R5, R7: writes outside the writable range leave every register alone
   assert_hole_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && (wr_addr == 8'h00 || wr_addr > 8'(NREG_RW)) && !cal_done)
      |=> $stable(bank));

   // R8: a done pulse clears the command bit unless a bus write lands there
   assert_cal_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && !(wr_stb && wr_addr == 8'(CAL_REG))) |=> !cal_busy);

   localparam int UNUSED_W = BANK_W;

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target #(
   parameter logic [4:0] ADDR_PREFIX = 5'b10001,
   parameter logic [3:0] DEV_ID      = 4'h1,
   parameter logic [3:0] DEV_REV     = 4'h0,
   parameter int         NREG_RW     = 12,
   parameter int         CAL_REG     = 12,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   input  logic [1:0]           strap,
   input  logic                 cal_done,
   output logic                 sda_pull,
   output logic [NREG_RW*8-1:0] cfg_bank,
   output logic                 cal_busy
);

   logic       scl_f, sda_f;
   logic       wr_stb;
   logic [7:0] wr_addr, wr_data, ptr, rd_data;

   i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (scl_i),
      .clean (scl_f)
   );

   i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (sda_i),
      .clean (sda_f)
   );

   i2c_bus_engine #(.ADDR_PREFIX(ADDR_PREFIX)) u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl     (scl_f),
      .sda     (sda_f),
      .strap   (strap),
      .rd_data (rd_data),
      .sda_oe  (sda_pull),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .ptr     (ptr)
   );

   i2c_reg_bank #(
      .NREG_RW (NREG_RW),
      .CAL_REG (CAL_REG),
      .DEV_ID  (DEV_ID),
      .DEV_REV (DEV_REV)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .cal_done (cal_done),
      .rd_addr  (ptr),
      .rd_data  (rd_data),
      .bank     (cfg_bank),
      .cal_busy (cal_busy)
   );

endmodule

// File: tb/i2c_cfg_target_test.sv
module i2c_cfg_target_test;

   localparam int Q = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       cal_done = 1'b0;
   logic [1:0] strap = 2'b10;
   logic       sda_pull, cal_busy;
   logic [95:0] bank;
   logic       sda_line;

   assign sda_line = sda_m & ~sda_pull;

   always #10 clk = ~clk;

   i2c_cfg_target uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .strap(strap), .cal_done(cal_done), .sda_pull(sda_pull),
      .cfg_bank(bank), .cal_busy(cal_busy)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;
   logic [7:0] model [1:12];
   logic [7:0] mptr = 8'h00;

   task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] def_val(input int k);
      if (k == 1) return 8'h02;
      if (k >= 6 && k <= 8) return 8'h40;
      return 8'h00;
   endfunction

   function automatic logic [7:0] exp_read(input logic [7:0] a);
      if (a == 8'h00) return 8'h10;
      if (a >= 8'd1 && a <= 8'd12) return model[a];
      return 8'h00;
   endfunction

   function automatic logic [95:0] exp_bank();
      logic [95:0] v;
      for (int k = 1; k <= 12; k++) v[k*8-1 -: 8] = model[k];
      return v;
   endfunction

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      scl_m = 1'b0; wq();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      scl_m = 1'b0; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b1; wq(); wq();
   endtask

   task automatic bit_out(input logic b, input bit glitch);
      scl_m = 1'b0; wq();
      sda_m = b;
      if (glitch) begin
         repeat (3) @(negedge clk);
         scl_m = 1'b1;
         repeat (2) @(negedge clk);
         scl_m = 1'b0;
         @(negedge clk);
      end else begin
         wq();
      end
      scl_m = 1'b1; wq();
      if (glitch && b) begin
         sda_m = 1'b0;
         repeat (2) @(negedge clk);
         sda_m = 1'b1;
      end
      wq();
   endtask

   task automatic bit_in(output logic b);
      scl_m = 1'b0; wq();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      b = sda_line; wq();
   endtask

   task automatic send_byte(input logic [7:0] v, input bit glitch, output logic ack);
      logic l;
      for (int i = 7; i >= 0; i--) bit_out(v[i], glitch);
      bit_in(l);
      ack = ~l;
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] v);
      for (int i = 7; i >= 0; i--) begin
         logic b;
         bit_in(b);
         v[i] = b;
      end
      bit_out(~give_ack, 1'b0);
   endtask

   function automatic logic [7:0] addr_byte(input logic rd);
      return {5'b10001, strap, rd};
   endfunction

   task automatic write_txn(input logic [7:0] start, input int n,
                            input logic [7:0] d [4], input bit glitch, input string req);
      logic ack;
      bus_start();
      send_byte(addr_byte(1'b0), glitch, ack); chk({req, " addr ack"}, ack, 1'b1);
      send_byte(start, glitch, ack);           chk({req, " ptr ack"}, ack, 1'b1);
      mptr = start;
      for (int i = 0; i < n; i++) begin
         send_byte(d[i], glitch, ack);
         chk({req, " data ack"}, ack, 1'b1);
         if (mptr >= 8'd1 && mptr <= 8'd12) model[mptr] = d[i];
         mptr = mptr + 8'd1;
      end
      bus_stop();
   endtask

   task automatic read_run(input bit set_ptr, input logic [7:0] start, input int n, input string req);
      logic ack, l;
      logic [7:0] v;
      if (set_ptr) begin
         bus_start();
         send_byte(addr_byte(1'b0), 1'b0, ack); chk({req, " w-addr ack"}, ack, 1'b1);
         send_byte(start, 1'b0, ack);           chk({req, " ptr ack"}, ack, 1'b1);
         mptr = start;
      end
      bus_start();
      send_byte(addr_byte(1'b1), 1'b0, ack); chk({req, " r-addr ack"}, ack, 1'b1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n - 1, v);
         chk({req, " read data"}, v, exp_read(mptr));
         mptr = mptr + 8'd1;
      end
      // R10: after the NACK the target must leave the line alone
      bit_in(l);
      chk("R10 released after NACK", l, 1'b1);
      bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] d [4];
      logic ack;
      void'($urandom(32'd20240611));
      for (int k = 1; k <= 12; k++) model[k] = def_val(k);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R6, R11: reset values and bank layout
      chk("R6 reset bank", bank, exp_bank());
      chk("R8 reset cal_busy", cal_busy, 1'b0);
      chk("R10 reset line free", sda_pull, 1'b0);

      // R5, R4: identity then a run of all writable registers
      read_run(1'b1, 8'h00, 1, "R5 id read");
      read_run(1'b1, 8'h01, 12, "R4 run read R6");
      // R4: a read with no pointer byte continues from the last one
      read_run(1'b1, 8'h03, 2, "R4 first");
      read_run(1'b0, 8'h00, 2, "R4 continue");

      // R5: write to the identity byte is acked and ignored
      d = '{8'hFF, 8'hA5, 8'h00, 8'h00};
      write_txn(8'h00, 1, d, 1'b0, "R5 id write");
      read_run(1'b1, 8'h00, 1, "R5 id after write");

      // R7: empty range writes acked, ignored; reads give zero
      d = '{8'h11, 8'h22, 8'h33, 8'h44};
      write_txn(8'h0D, 4, d, 1'b0, "R7 hole write");
      chk("R7 bank unchanged", bank, exp_bank());
      read_run(1'b1, 8'h10, 4, "R7 hole read");

      // R2: wrong prefix and wrong strap are not acknowledged
      bus_start();
      send_byte({5'b10011, strap, 1'b0}, 1'b0, ack);
      chk("R2 wrong prefix nack", ack, 1'b0);
      send_byte(8'h01, 1'b0, ack); chk("R2 ignored ptr", ack, 1'b0);
      send_byte(8'h77, 1'b0, ack); chk("R2 ignored data", ack, 1'b0);
      bus_stop();
      bus_start();
      send_byte({5'b10001, ~strap, 1'b0}, 1'b0, ack);
      chk("R2 wrong strap nack", ack, 1'b0);
      bus_stop();
      chk("R2 bank unchanged", bank, exp_bank());

      // R1: each strap value selects its own address
      for (int s = 0; s < 4; s++) begin
         strap = 2'(s);
         repeat (4) @(negedge clk);
         bus_start();
         send_byte(addr_byte(1'b0), 1'b0, ack);
         chk("R1 strap address ack", ack, 1'b1);
         bus_stop();
      end
      strap = 2'b01;

      // R8: calibration bit set by bus, cleared by done pulse
      d = '{8'h81, 8'h00, 8'h00, 8'h00};
      write_txn(8'h0C, 1, d, 1'b0, "R8 cal write");
      chk("R8 cal_busy set", cal_busy, 1'b1);
      @(negedge clk); cal_done = 1'b1;
      @(negedge clk); cal_done = 1'b0;
      @(negedge clk);
      model[12][0] = 1'b0;
      chk("R8 cal_busy cleared", cal_busy, 1'b0);
      read_run(1'b1, 8'h0C, 1, "R8 cal readback");

      // R9: short pulses on both lines during a write
      d = '{8'h5A, 8'hC3, 8'h0F, 8'hF0};
      write_txn(8'h02, 4, d, 1'b1, "R9 glitch write");
      chk("R9 bank after glitches", bank, exp_bank());

      // R3, R4, R11: random writes and reads
      for (int t = 0; t < 24; t++) begin
         logic [7:0] st;
         int n;
         st = 8'($urandom_range(0, 21));
         n = int'($urandom_range(1, 4));
         for (int i = 0; i < 4; i++) d[i] = 8'($urandom) & 8'hFE;
         write_txn(st, n, d, 1'b0, "R3 random write");
         chk("R11 bank layout", bank, exp_bank());
         st = 8'($urandom_range(0, 21));
         read_run(1'b1, st, int'($urandom_range(1, 4)), "R4 random read");
      end

      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule